// File: doc/BRIEF.md
# Snapshot-Read 64-bit Free-Running Counter

This block keeps a wide free-running up-counter that advances by one on every clock edge where a count-enable tick is high. Software reads it over a 32-bit register port. A direct read of two 32-bit halves would give a torn value whenever a carry crosses between them. To avoid that, software first asks for a snapshot by setting a request bit in a control register. The block copies the live counter into shadow storage after a fixed synchronisation delay. It then clears the request bit to show that the copy is ready.

Software polls the request bit until it reads zero. It then reads the lower and upper halves of the shadow copy from two separate registers, in either order. Both halves come from the same instant, however far the live counter has moved on. The shadow copy stays unchanged until the next request. Counting never pauses.

Top module: `snap_timer64`

## Requirements
- R1: Reset (synchronous, active high) clears the live counter, the shadow copy and the request bit, so every register reads zero afterwards.
- R2: The live counter increases by exactly one on each clock edge where `tick` is high and holds its value on edges where `tick` is low.
- R3: A write to offset 0xA0 with data bit 1 set starts a snapshot request. While the request is outstanding, a read of 0xA0 returns 0x0000_0002. Otherwise it returns zero.
- R4: The request bit clears on the clock edge that comes `SYNC_CYCLES` edges after the write edge (2 by default). The shadow copy then holds the live counter value present just before that edge; a tick sampled on that same edge is not included.
- R5: A read of offset 0xA4 returns the shadow bits 31:0 and a read of 0xA8 returns bits 63:32. The shadow copy does not change until the next accepted request, while counting goes on.
- R6: A request written while another is outstanding is ignored. It does not restart the wait, so completion still falls `SYNC_CYCLES` edges after the first write.
- R7: A write to 0xA0 with bit 1 clear, and any write to another offset, leaves the request bit and the shadow copy unchanged.
- R8: The counter wraps from all ones to zero. With `CNT_W` of 32 or less, offset 0xA8 reads zero.
- R9: Read data is registered: it appears on the edge that samples `bus_rd` and holds while `bus_rd` is low. A read of any offset other than 0xA0, 0xA4 or 0xA8 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, sampled on each rising edge |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
The snapshot capture and a counter increment can fall on the same clock edge, and a half of the shadow copy can be read while the live counter keeps moving. The bench keeps `tick` high through a whole request window. It notes its own model count one edge before completion, and requires both halves to match that value even though they are read several increments later. It also times the request bit to the exact edge, so a capture shifted by one cycle, or a wait restarted by a second request, shows up as a mismatch.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam int unsigned BUS_W    = 32;
  localparam int unsigned OFS_CTRL = 'hA0;
  localparam int unsigned OFS_LO   = 'hA4;
  localparam int unsigned OFS_HI   = 'hA8;
  localparam int unsigned REQ_BIT  = 1;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_LO,
    SEL_HI
  } reg_sel_e;
endpackage

// File: rtl/snap_free_counter.sv
module snap_free_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (tick) count <= count + CNT_W'(1);
  end

  // R2: one step per enabled edge, wrapping past all ones (R8)
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> count == $past(count) + CNT_W'(1));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));
endmodule

// File: rtl/snap_latch_ctrl.sv
module snap_latch_ctrl #(
  parameter int unsigned CNT_W       = 64,
  parameter int unsigned SYNC_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_wr,
  input  logic [CNT_W-1:0] live,
  output logic             pending,
  output logic [CNT_W-1:0] shadow
);
  localparam int unsigned WAIT_W = (SYNC_CYCLES > 1) ? $clog2(SYNC_CYCLES) : 1;
  localparam logic [WAIT_W-1:0] LAST = WAIT_W'(SYNC_CYCLES - 1);

  logic [WAIT_W-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      wait_q  <= '0;
      shadow  <= '0;
    end else if (!pending) begin
      if (req_wr) begin
        pending <= 1'b1;
        wait_q  <= '0;
      end
    end else if (wait_q == LAST) begin
      pending <= 1'b0;
      wait_q  <= '0;
      shadow  <= live;
    end else begin
      wait_q <= wait_q + WAIT_W'(1);
    end
  end

  // R3: an accepted request raises the pending bit
  a_r3_start: assert property (@(posedge clk) disable iff (rst)
    (req_wr && !pending) |=> pending);
  // R6: wait advances without restart while outstanding
  a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
    (pending && wait_q != LAST) |=> (pending && wait_q == $past(wait_q) + WAIT_W'(1)));
  // R4: capture takes the live value of the completion edge
  a_r4_capture: assert property (@(posedge clk) disable iff (rst)
    ($fell(pending) && !$past(rst)) |-> shadow == $past(live));
  // R5: shadow is frozen when no request is outstanding
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !pending |=> $stable(shadow));
endmodule

// File: rtl/snap_bus_port.sv
module snap_bus_port
  import snap_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              rd,
  input  logic              pending,
  input  logic [CNT_W-1:0]  shadow,
  output logic              req_wr,
  output logic [BUS_W-1:0]  rdata
);
  reg_sel_e         sel;
  logic [BUS_W-1:0] half_lo;
  logic [BUS_W-1:0] half_hi;
  logic             unused_wdata;

  always_comb begin
    if (addr == ADDR_W'(OFS_CTRL))    sel = SEL_CTRL;
    else if (addr == ADDR_W'(OFS_LO)) sel = SEL_LO;
    else if (addr == ADDR_W'(OFS_HI)) sel = SEL_HI;
    else                              sel = SEL_NONE;
  end

  generate
    if (CNT_W > BUS_W) begin : g_wide
      assign half_lo = shadow[BUS_W-1:0];
      assign half_hi = BUS_W'(shadow[CNT_W-1:BUS_W]);
    end else begin : g_narrow
      assign half_lo = BUS_W'(shadow);
      assign half_hi = '0;
    end
  endgenerate

  assign req_wr       = wr && (sel == SEL_CTRL) && wdata[REQ_BIT];
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      case (sel)
        SEL_CTRL: rdata <= BUS_W'(pending) << REQ_BIT;
        SEL_LO:   rdata <= half_lo;
        SEL_HI:   rdata <= half_hi;
        default:  rdata <= '0;
      endcase
    end
  end

  // R9: read data is held between read strobes
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
  // R3: a control read never shows bits other than the request bit
  a_r3_ctrl_bits: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_CTRL) |=> (rdata & ~(BUS_W'(1) << REQ_BIT)) == '0);
endmodule

// File: rtl/snap_timer64.sv
module snap_timer64
  import snap_pkg::*;
#(
  parameter int unsigned CNT_W       = 64,
  parameter int unsigned SYNC_CYCLES = 2,
  parameter int unsigned ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata
);
  logic [CNT_W-1:0] live;
  logic [CNT_W-1:0] shadow;
  logic             pending;
  logic             req_wr;

  snap_free_counter #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .count (live)
  );

  snap_latch_ctrl #(.CNT_W(CNT_W), .SYNC_CYCLES(SYNC_CYCLES)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .req_wr  (req_wr),
    .live    (live),
    .pending (pending),
    .shadow  (shadow)
  );

  snap_bus_port #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_port (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .wr      (bus_wr),
    .wdata   (bus_wdata),
    .rd      (bus_rd),
    .pending (pending),
    .shadow  (shadow),
    .req_wr  (req_wr),
    .rdata   (bus_rdata)
  );
endmodule

// File: tb/tb_snap_timer64.sv
`timescale 1ns/1ps
module tb_snap_timer64;
  localparam int unsigned LAT = 2;
  localparam logic [7:0] A_CTRL = 8'hA0;
  localparam logic [7:0] A_LO   = 8'hA4;
  localparam logic [7:0] A_HI   = 8'hA8;
  localparam int NV = 6;
  localparam int unsigned RUNS [NV] = '{5, 0, 17, 1, 100, 250};
  localparam logic [63:0] EXPS [NV] = '{64'd5, 64'd5, 64'd22, 64'd23, 64'd123, 64'd373};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd = 1'b0;
  wire  [31:0] rdata;
  wire  [31:0] rdata_w;

  int nchecks = 0;
  int nerr = 0;
  bit done = 1'b0;
  logic [63:0] ref_cnt;
  logic [31:0] got, got_w;
  logic [63:0] v, expv;
  logic [31:0] vw;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) ref_cnt <= '0;
    else if (tick) ref_cnt <= ref_cnt + 64'd1;
  end

  snap_timer64 #(.CNT_W(64), .SYNC_CYCLES(LAT), .ADDR_W(8)) dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(rdata));

  snap_timer64 #(.CNT_W(8), .SYNC_CYCLES(LAT), .ADDR_W(8)) dut_wrap (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(rdata_w));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a);
    addr = a; rd = 1'b1;
    @(posedge clk); @(negedge clk);
    rd = 1'b0;
    got = rdata; got_w = rdata_w;
  endtask

  task automatic run_ticks(input int unsigned n);
    for (int i = 0; i < int'(n); i++) begin
      tick = 1'b1;
      @(posedge clk); @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic snap_read;
    wr_reg(A_CTRL, 32'h2);
    for (int i = 0; i < 20; i++) begin
      rd_reg(A_CTRL);
      if (got[1] == 1'b0) break;
    end
    chk("R3 request bit clears after poll", 64'(got), 64'd0);
    rd_reg(A_HI); v[63:32] = got;
    rd_reg(A_LO); v[31:0] = got; vw = got_w;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    rd_reg(A_CTRL); chk("R1 ctrl after reset", 64'(got), 64'd0);
    rd_reg(A_LO);   chk("R1 low after reset", 64'(got), 64'd0);
    rd_reg(A_HI);   chk("R1 high after reset", 64'(got), 64'd0);

    // R2 / R5: vector table of tick runs and snapshot values
    for (int i = 0; i < NV; i++) begin
      run_ticks(RUNS[i]);
      snap_read();
      chk($sformatf("R2 R5 vector %0d", i), v, EXPS[i]);
    end

    // R8: narrow instance wraps past all ones (373 mod 256)
    chk("R8 narrow low wraps", 64'(vw), 64'd117);
    rd_reg(A_HI); chk("R8 narrow high reads zero", 64'(got_w), 64'd0);

    // R9: registered read, hold, unmapped offsets
    rd_reg(A_LO); chk("R9 read low", 64'(got), 64'd373);
    @(negedge clk); chk("R9 rdata holds without strobe", 64'(rdata), 64'd373);
    rd_reg(8'h10); chk("R9 unmapped 0x10", 64'(got), 64'd0);
    rd_reg(8'hAC); chk("R9 unmapped 0xAC", 64'(got), 64'd0);

    // R5: shadow stays while live counter moves
    run_ticks(10);
    rd_reg(A_LO); chk("R5 low frozen", 64'(got), 64'd373);
    rd_reg(A_HI); chk("R5 high frozen", 64'(got), 64'd0);

    // R7: writes that must not request
    wr_reg(A_CTRL, 32'hFFFF_FFFD);
    rd_reg(A_CTRL); chk("R7 bit1 clear no request", 64'(got), 64'd0);
    wr_reg(A_LO, 32'h2); wr_reg(A_HI, 32'h2); wr_reg(8'h00, 32'h2);
    rd_reg(A_CTRL); chk("R7 other offsets no request", 64'(got), 64'd0);
    rd_reg(A_LO); chk("R7 shadow unchanged", 64'(got), 64'd373);

    // R4: exact completion edge with counting through the window
    tick = 1'b1;
    addr = A_CTRL; wdata = 32'h2; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
    for (int k = 1; k < int'(LAT); k++) begin
      rd_reg(A_CTRL); chk("R3 request visible in window", 64'(got), 64'd2);
    end
    expv = ref_cnt;
    rd_reg(A_CTRL); chk("R4 bit still set before completion edge", 64'(got), 64'd2);
    rd_reg(A_CTRL); chk("R4 bit clear after completion edge", 64'(got), 64'd0);
    rd_reg(A_HI); v[63:32] = got;
    rd_reg(A_LO); v[31:0] = got;
    chk("R4 value captured while ticking", v, expv);
    rd_reg(A_HI); chk("R5 high coherent while ticking", 64'(got), 64'(expv[63:32]));
    tick = 1'b0;

    // R6: second request inside window is ignored
    run_ticks(3);
    wr_reg(A_CTRL, 32'h2);
    wr_reg(A_CTRL, 32'h2);
    for (int k = 2; k <= int'(LAT); k++) begin
      rd_reg(A_CTRL); chk("R6 still pending", 64'(got), 64'd2);
    end
    rd_reg(A_CTRL); chk("R6 completion not delayed", 64'(got), 64'd0);
    rd_reg(A_LO); chk("R6 snapshot value", 64'(got), 64'(ref_cnt[31:0]));

    // R1: reset in mid-run clears counter and shadow
    run_ticks(5);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    rd_reg(A_LO); chk("R1 shadow low cleared", 64'(got), 64'd0);
    rd_reg(A_CTRL); chk("R1 request cleared", 64'(got), 64'd0);
    snap_read();
    chk("R1 counter cleared", v, 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule